// File: doc/BRIEF.md
# Unified Multi-Page-Size Translation Buffer

This block is a fully associative translation cache. Instruction fetches and data accesses both look up the same set of entries, using one port. A lookup presents a modified virtual address with the privilege level and direction of the access. One cycle later the block reports one of three results:
- a clean hit, with the physical address and the cacheable and bufferable attributes;
- an abort, when the permission or domain check fails;
- a miss.

Every entry maps a region of one of four sizes: a 1 MB section, a 64 KB large page, a 4 KB small page or a 1 KB tiny page. An external table walker answers a miss through the refill port. Refilled translations go into the lowest-numbered free slot that is not locked. When no such slot is free, a round-robin victim is chosen among the unlocked slots.

A maintenance port carries four commands: invalidate everything, invalidate by address, and set the count of locked low-numbered slots. The fourth code is a no-op. Locked slots are never chosen for replacement.

Top module: `utlb_top`

## Requirements
- R1: An entry hits when its valid bit is set and the virtual page bits above its size's offset agree with the lookup address. The offset field is bits [19:0] for size code 0 (1 MB), [15:0] for code 1 (64 KB), [11:0] for code 2 (4 KB) and [9:0] for code 3 (1 KB). On a clean hit, the physical address is the entry's base above the offset field, joined with the lookup address inside it.
- R2: `rf_ap` holds four 2-bit permission fields, and field q occupies bits [2q+1:2q]. A 64 KB page selects the field by address bits [15:14]. A 4 KB page selects it by bits [11:10]. Sections and tiny pages always use field 0.
- R3: The permission codes for a client domain are as follows. Code 00 denies every access. Code 01 allows privileged accesses only. Code 10 allows privileged accesses and unprivileged reads. Code 11 allows all accesses.
- R4: `dom_ctl` holds 2 bits per domain, and domain d occupies bits [2d+1:2d]. Code 11 (manager) skips the permission check. Code 01 (client) applies the check. Codes 00 and 10 abort every access.
- R5: Results appear in the cycle after the lookup is issued. `res_valid` is high exactly in the cycles that follow a cycle with `lk_valid` high.
- R6: A valid result raises exactly one of `res_hit` and `res_miss`. `res_abort` implies `res_hit`. `res_pa` and both attribute outputs are zero unless the result is a hit without an abort. When several entries match, the lowest-numbered one supplies the result.
- R7: Maintenance op 1 clears every entry. This includes locked entries and a refill written in the same cycle.
- R8: Maintenance op 2 clears only the entries whose page, taken at each entry's own size, contains the page number on `mt_vpn`.
- R9: A refill goes to the lowest-numbered slot that is invalid and whose index is at least the lock count.
- R10: Maintenance op 3 sets the lock count from `mt_lock`, and slots below the lock count are never overwritten by a refill. When no unlocked slot is free, a round-robin pointer picks the victim. The pointer is raised to the lock count if it is below it, and after use it advances, wrapping back to the lock count.
- R11: A lookup issued in the same cycle as a maintenance command sees the table as it was before the command. The next lookup sees it after the command.
- R12: After reset, all entries are invalid, the lock count and round-robin pointer are zero, and every result output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Modified virtual address to translate |
| lk_priv | input | 1 | Access is privileged |
| lk_write | input | 1 | Access is a write |
| dom_ctl | input | 32 | Domain control, 2 bits per domain |
| res_valid | output | 1 | Result of the previous cycle's lookup is present |
| res_hit | output | 1 | A matching entry was found |
| res_miss | output | 1 | No entry matched |
| res_abort | output | 1 | Matching entry failed the domain or permission check |
| res_pa | output | 32 | Physical address on a clean hit, else zero |
| res_cacheable | output | 1 | Cacheable attribute on a clean hit |
| res_bufferable | output | 1 | Bufferable attribute on a clean hit |
| rf_valid | input | 1 | Refill write |
| rf_vpn | input | 22 | Virtual address bits [31:10] of the refill |
| rf_ppn | input | 22 | Physical address bits [31:10] of the refill |
| rf_size | input | 2 | Size code (0 1 MB, 1 64 KB, 2 4 KB, 3 1 KB) |
| rf_dom | input | 4 | Domain number |
| rf_ap | input | 8 | Four 2-bit permission fields |
| rf_cacheable | input | 1 | Cacheable attribute |
| rf_bufferable | input | 1 | Bufferable attribute |
| mt_valid | input | 1 | Maintenance command |
| mt_op | input | 2 | 0 none, 1 invalidate all, 2 invalidate by address, 3 set lock count |
| mt_vpn | input | 22 | Virtual address bits [31:10] for op 2 |
| mt_lock | input | 4 | Lock count for op 3 |

## Verification
Every lookup result is registered once, so it is due exactly one cycle after the request. The bench drives each request on a falling edge and reads the result on the following falling edge. A refill or maintenance command also takes effect at the rising edge that follows it. Lookups that check those commands are therefore issued in the next cycle, except in the same-cycle test, where the lookup and the command share a cycle on purpose. The replacement order cannot be seen directly at the ports. The bench shows it by performing a sequence of refills and then recording which of the earlier pages still hit.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_LSB = 10;
    localparam int VPN_W  = VA_W - PG_LSB;

    typedef enum logic [1:0] {
        PG_SECTION = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SMALL   = 2'd2,
        PG_TINY    = 2'd3
    } pgsize_e;

    typedef enum logic [1:0] {
        MT_NOP     = 2'd0,
        MT_INV_ALL = 2'd1,
        MT_INV_VA  = 2'd2,
        MT_SET_LCK = 2'd3
    } mtop_e;

    localparam logic [1:0] DOM_CLIENT  = 2'b01;
    localparam logic [1:0] DOM_MANAGER = 2'b11;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        pgsize_e          size;
        logic [VPN_W-1:0] ppn;
        logic [3:0]       dom;
        logic [7:0]       ap;
        logic             cacheable;
        logic             bufferable;
    } tlb_entry_t;

    // Page-number bits that take part in the compare for a given size.
    function automatic logic [VPN_W-1:0] keep_mask(pgsize_e s);
        int drop;
        case (s)
            PG_SECTION: drop = 10;
            PG_LARGE:   drop = 6;
            PG_SMALL:   drop = 2;
            default:    drop = 0;
        endcase
        return {VPN_W{1'b1}} << drop;
    endfunction

    function automatic logic [1:0] quarter_of(pgsize_e s, logic [VPN_W-1:0] vpn);
        case (s)
            PG_LARGE: return vpn[5:4];
            PG_SMALL: return vpn[1:0];
            default:  return 2'd0;
        endcase
    endfunction

    function automatic logic ap_allows(logic [1:0] ap, logic priv, logic wr);
        case (ap)
            2'b00:   return 1'b0;
            2'b01:   return priv;
            2'b10:   return priv | ~wr;
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/utlb_slot.sv
module utlb_slot
    import utlb_pkg::*;
(
    input  logic             valid,
    input  logic [VPN_W-1:0] vpn,
    input  pgsize_e          size,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [VPN_W-1:0] mt_vpn,
    output logic             lk_hit,
    output logic             inv_hit
);
    logic [VPN_W-1:0] m;
    assign m       = keep_mask(size);
    assign lk_hit  = valid && (((vpn ^ lk_vpn) & m) == '0);
    assign inv_hit = valid && (((vpn ^ mt_vpn) & m) == '0);
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_v,
    input  logic [IW-1:0]      lock_cnt,
    input  logic               take,
    output logic [IW-1:0]      victim
);
    logic [IW-1:0] rr, rr_eff, free_idx;
    logic          free_found;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_v[i] && IW'(i) >= lock_cnt) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
        rr_eff = (rr < lock_cnt) ? lock_cnt : rr;
        victim = free_found ? free_idx : rr_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr <= '0;
        end else if (take && !free_found) begin
            rr <= (rr_eff == IW'(ENTRIES - 1)) ? lock_cnt : rr_eff + 1'b1;
        end
    end
endmodule

// File: rtl/utlb_access.sv
module utlb_access
    import utlb_pkg::*;
(
    input  pgsize_e          size,
    input  logic [VPN_W-1:0] ppn,
    input  logic [3:0]       dom,
    input  logic [7:0]       ap,
    input  logic [VA_W-1:0]  va,
    input  logic             priv,
    input  logic             wr,
    input  logic [31:0]      dom_ctl,
    output logic             fault,
    output logic [VA_W-1:0]  pa
);
    logic [VPN_W-1:0] m, vpn;
    logic [1:0]       q, dc, ap_sel;

    assign vpn    = va[VA_W-1:PG_LSB];
    assign m      = keep_mask(size);
    assign q      = quarter_of(size, vpn);
    assign ap_sel = ap[{q, 1'b0} +: 2];
    assign dc     = dom_ctl[{dom, 1'b0} +: 2];
    assign pa     = {(ppn & m) | (vpn & ~m), va[PG_LSB-1:0]};

    always_comb begin
        case (dc)
            DOM_MANAGER: fault = 1'b0;
            DOM_CLIENT:  fault = !ap_allows(ap_sel, priv, wr);
            default:     fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/utlb_top.sv
module utlb_top
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       lk_valid,
    input  logic [31:0]                lk_va,
    input  logic                       lk_priv,
    input  logic                       lk_write,
    input  logic [31:0]                dom_ctl,
    output logic                       res_valid,
    output logic                       res_hit,
    output logic                       res_miss,
    output logic                       res_abort,
    output logic [31:0]                res_pa,
    output logic                       res_cacheable,
    output logic                       res_bufferable,
    input  logic                       rf_valid,
    input  logic [21:0]                rf_vpn,
    input  logic [21:0]                rf_ppn,
    input  logic [1:0]                 rf_size,
    input  logic [3:0]                 rf_dom,
    input  logic [7:0]                 rf_ap,
    input  logic                       rf_cacheable,
    input  logic                       rf_bufferable,
    input  logic                       mt_valid,
    input  logic [1:0]                 mt_op,
    input  logic [21:0]                mt_vpn,
    input  logic [$clog2(ENTRIES)-1:0] mt_lock
);
    localparam int IW = $clog2(ENTRIES);

    tlb_entry_t         tbl [ENTRIES];
    tlb_entry_t         rf_ent, sel;
    logic [ENTRIES-1:0] lk_hitv, inv_hitv, valid_v;
    logic [IW-1:0]      sel_idx, lock_cnt, victim;
    logic               any_hit, fault;
    logic [31:0]        pa;
    logic               do_inv_all, do_inv_va, do_lock;

    assign do_inv_all = mt_valid && (mt_op == MT_INV_ALL);
    assign do_inv_va  = mt_valid && (mt_op == MT_INV_VA);
    assign do_lock    = mt_valid && (mt_op == MT_SET_LCK);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign valid_v[g] = tbl[g].valid;
        utlb_slot u_slot (
            .valid   (tbl[g].valid),
            .vpn     (tbl[g].vpn),
            .size    (tbl[g].size),
            .lk_vpn  (lk_va[31:PG_LSB]),
            .mt_vpn  (mt_vpn),
            .lk_hit  (lk_hitv[g]),
            .inv_hit (inv_hitv[g])
        );
    end

    always_comb begin
        sel_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_hitv[i]) sel_idx = IW'(i);
        end
    end
    assign any_hit = |lk_hitv;
    assign sel     = tbl[sel_idx];

    utlb_access u_access (
        .size    (sel.size),
        .ppn     (sel.ppn),
        .dom     (sel.dom),
        .ap      (sel.ap),
        .va      (lk_va),
        .priv    (lk_priv),
        .wr      (lk_write),
        .dom_ctl (dom_ctl),
        .fault   (fault),
        .pa      (pa)
    );

    utlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .valid_v  (valid_v),
        .lock_cnt (lock_cnt),
        .take     (rf_valid),
        .victim   (victim)
    );

    always_comb begin
        rf_ent.valid      = 1'b1;
        rf_ent.vpn        = rf_vpn;
        rf_ent.size       = pgsize_e'(rf_size);
        rf_ent.ppn        = rf_ppn;
        rf_ent.dom        = rf_dom;
        rf_ent.ap         = rf_ap;
        rf_ent.cacheable  = rf_cacheable;
        rf_ent.bufferable = rf_bufferable;
    end

    // Order of update within a cycle: address invalidate, refill, full invalidate.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
            lock_cnt <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (do_inv_va && inv_hitv[i]) tbl[i].valid <= 1'b0;
                if (rf_valid && victim == IW'(i)) tbl[i] <= rf_ent;
                if (do_inv_all) tbl[i].valid <= 1'b0;
            end
            if (do_lock) lock_cnt <= mt_lock;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid      <= 1'b0;
            res_hit        <= 1'b0;
            res_miss       <= 1'b0;
            res_abort      <= 1'b0;
            res_pa         <= '0;
            res_cacheable  <= 1'b0;
            res_bufferable <= 1'b0;
        end else begin
            res_valid      <= lk_valid;
            res_hit        <= lk_valid && any_hit;
            res_miss       <= lk_valid && !any_hit;
            res_abort      <= lk_valid && any_hit && fault;
            res_pa         <= (lk_valid && any_hit && !fault) ? pa : '0;
            res_cacheable  <= lk_valid && any_hit && !fault && sel.cacheable;
            res_bufferable <= lk_valid && any_hit && !fault && sel.bufferable;
        end
    end
endmodule

// File: rtl/utlb_chk.sv
module utlb_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic        mt_valid,
    input logic [1:0]  mt_op,
    input logic        res_valid,
    input logic        res_hit,
    input logic        res_miss,
    input logic        res_abort,
    input logic [31:0] res_pa,
    input logic        res_cacheable,
    input logic        res_bufferable
);
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!res_valid && !res_hit && !res_miss && !res_abort));

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $onehot({res_hit, res_miss}));

    assert_abort_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
        res_abort |-> res_hit);

    assert_quiet_pa_R6: assert property (@(posedge clk) disable iff (rst)
        (res_abort || !res_hit) |-> (res_pa == '0 && !res_cacheable && !res_bufferable));

    assert_flush_misses_R7: assert property (@(posedge clk) disable iff (rst)
        (mt_valid && mt_op == 2'd1) ##1 lk_valid |=> res_miss);
endmodule

bind utlb_top utlb_chk u_utlb_chk (.*);

// File: tb/test_utlb_top.sv
module test_utlb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, lk_priv, lk_write;
    logic [31:0] lk_va, dom_ctl;
    logic        res_valid, res_hit, res_miss, res_abort, res_cacheable, res_bufferable;
    logic [31:0] res_pa;
    logic        rf_valid, rf_cacheable, rf_bufferable;
    logic [21:0] rf_vpn, rf_ppn, mt_vpn;
    logic [1:0]  rf_size, mt_op;
    logic [3:0]  rf_dom, mt_lock;
    logic [7:0]  rf_ap;
    logic        mt_valid;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    utlb_top i_utlb_top (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(logic [31:0] va, logic priv, logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_priv = priv; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // outcome packed as {valid, hit, miss, abort}
    task automatic expect_res(string req, logic [31:0] va, logic priv, logic wr,
                              logic [3:0] flags, logic [31:0] pa);
        lookup(va, priv, wr);
        check(req, {28'd0, res_valid, res_hit, res_miss, res_abort}, {28'd0, flags});
        check(req, res_pa, pa);
    endtask

    task automatic refill(logic [31:0] va, logic [31:0] pa, logic [1:0] sz,
                          logic [3:0] dom, logic [7:0] ap);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = va[31:10]; rf_ppn = pa[31:10];
        rf_size = sz; rf_dom = dom; rf_ap = ap; rf_cacheable = 1'b1; rf_bufferable = 1'b0;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic maint(logic [1:0] op, logic [31:0] va, logic [3:0] lk);
        @(negedge clk);
        mt_valid = 1'b1; mt_op = op; mt_vpn = va[31:10]; mt_lock = lk;
        @(negedge clk);
        mt_valid = 1'b0;
    endtask

    localparam logic [3:0] HIT = 4'b1100, MISS = 4'b1010, ABT = 4'b1101;

    task automatic t_reset;
        @(negedge clk);
        check("R12 outputs", {25'd0, res_valid, res_hit, res_miss, res_abort,
                              res_cacheable, res_bufferable, 1'b0}, 32'd0);
        expect_res("R12 empty table", 32'h1230_0000, 1'b1, 1'b0, MISS, 32'd0);
    endtask

    task automatic t_sizes;
        refill(32'h1230_0000, 32'h8000_0000, 2'd0, 4'd0, 8'hFF);
        lookup(32'h123A_BCDE, 1'b0, 1'b1);
        check("R1 section pa", res_pa, 32'h800A_BCDE);
        check("R1 section attr", {30'd0, res_cacheable, res_bufferable}, 32'd2);
        refill(32'h5000_3000, 32'h0000_7000, 2'd2, 4'd0, 8'hFF);
        expect_res("R1 small in", 32'h5000_3FFC, 1'b0, 1'b0, HIT, 32'h0000_7FFC);
        expect_res("R1 small out", 32'h5000_4000, 1'b0, 1'b0, MISS, 32'd0);
        refill(32'h6000_0400, 32'h0010_0C00, 2'd3, 4'd0, 8'hFF);
        expect_res("R1 tiny in", 32'h6000_07FF, 1'b0, 1'b0, HIT, 32'h0010_0FFF);
        expect_res("R1 tiny out", 32'h6000_0800, 1'b0, 1'b0, MISS, 32'd0);
    endtask

    task automatic t_quarters;
        // quarters: q0=11 q1=01 q2=10 q3=00
        refill(32'h4001_0000, 32'h00A0_0000, 2'd1, 4'd0, 8'b00_10_01_11);
        expect_res("R2 large q0 user", 32'h4001_0123, 1'b0, 1'b1, HIT, 32'h00A0_0123);
        expect_res("R3 q1 user abort", 32'h4001_4000, 1'b0, 1'b0, ABT, 32'd0);
        expect_res("R3 q1 priv ok", 32'h4001_4004, 1'b1, 1'b1, HIT, 32'h00A0_4004);
        expect_res("R3 q2 user write", 32'h4001_8000, 1'b0, 1'b1, ABT, 32'd0);
        expect_res("R3 q2 user read", 32'h4001_8000, 1'b0, 1'b0, HIT, 32'h00A0_8000);
        expect_res("R3 q3 priv abort", 32'h4001_C000, 1'b1, 1'b0, ABT, 32'd0);
        // 4 KB page, quarter by bits [11:10]: q2 = 00
        refill(32'h5100_0000, 32'h0200_0000, 2'd2, 4'd0, 8'b11_00_11_11);
        expect_res("R2 small q2", 32'h5100_0800, 1'b1, 1'b0, ABT, 32'd0);
        expect_res("R2 small q3", 32'h5100_0C00, 1'b0, 1'b1, HIT, 32'h0200_0C00);
        // section uses field 0 even at a high quarter offset
        refill(32'h2200_0000, 32'h0300_0000, 2'd0, 4'd0, 8'b11_11_11_00);
        expect_res("R2 section field0", 32'h220F_C000, 1'b1, 1'b0, ABT, 32'd0);
    endtask

    task automatic t_domains;
        refill(32'h2000_0000, 32'h3000_0000, 2'd0, 4'd3, 8'h00);
        expect_res("R4 manager bypass", 32'h2001_2345, 1'b0, 1'b1, HIT, 32'h3001_2345);
        refill(32'h2100_0000, 32'h3100_0000, 2'd0, 4'd5, 8'hFF);
        expect_res("R4 no access", 32'h2100_0010, 1'b1, 1'b0, ABT, 32'd0);
        refill(32'h2300_0000, 32'h3300_0000, 2'd0, 4'd2, 8'hFF);
        expect_res("R4 reserved", 32'h2300_0010, 1'b1, 1'b0, ABT, 32'd0);
    endtask

    task automatic t_invalidate;
        maint(2'd2, 32'h6000_07FF, 4'd0);
        expect_res("R8 tiny gone", 32'h6000_0400, 1'b1, 1'b0, MISS, 32'd0);
        expect_res("R8 section kept", 32'h1230_0004, 1'b1, 1'b0, HIT, 32'h8000_0004);
        maint(2'd2, 32'h123F_FFFF, 4'd0);
        expect_res("R8 section by inner addr", 32'h1230_0004, 1'b1, 1'b0, MISS, 32'd0);
        expect_res("R8 small kept", 32'h5000_3000, 1'b1, 1'b0, HIT, 32'h0000_7000);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        lk_valid = 1'b1; lk_va = 32'h5000_3010; lk_priv = 1'b1; lk_write = 1'b0;
        mt_valid = 1'b1; mt_op = 2'd1;
        @(negedge clk);
        lk_valid = 1'b0; mt_valid = 1'b0;
        check("R11 old state seen", res_pa, 32'h0000_7010);
        expect_res("R7 R11 flushed", 32'h5000_3010, 1'b1, 1'b0, MISS, 32'd0);
        expect_res("R7 domain entry flushed", 32'h2001_0000, 1'b1, 1'b0, MISS, 32'd0);
    endtask

    task automatic t_replace;
        for (int k = 0; k < 16; k++)
            refill(32'h7000_0000 + k * 32'h1000, 32'h1000_0000 + k * 32'h1000, 2'd2, 4'd0, 8'hFF);
        expect_res("R9 fill slot15", 32'h7000_F000, 1'b1, 1'b0, HIT, 32'h1000_F000);
        maint(2'd3, 32'd0, 4'd2);
        for (int j = 0; j < 3; j++)
            refill(32'h7100_0000 + j * 32'h1000, 32'h2000_0000 + j * 32'h1000, 2'd2, 4'd0, 8'hFF);
        expect_res("R10 locked0", 32'h7000_0000, 1'b1, 1'b0, HIT, 32'h1000_0000);
        expect_res("R10 locked1", 32'h7000_1000, 1'b1, 1'b0, HIT, 32'h1000_1000);
        expect_res("R10 evict2", 32'h7000_2000, 1'b1, 1'b0, MISS, 32'd0);
        expect_res("R10 evict4", 32'h7000_4000, 1'b1, 1'b0, MISS, 32'd0);
        expect_res("R10 kept5", 32'h7000_5000, 1'b1, 1'b0, HIT, 32'h1000_5000);
        expect_res("R10 new C", 32'h7100_2000, 1'b1, 1'b0, HIT, 32'h2000_2000);
        maint(2'd2, 32'h7000_7000, 4'd2);
        refill(32'h7200_0000, 32'h4000_0000, 2'd2, 4'd0, 8'hFF);
        refill(32'h7300_0000, 32'h5000_0000, 2'd2, 4'd0, 8'hFF);
        expect_res("R9 free slot used", 32'h7200_0000, 1'b1, 1'b0, HIT, 32'h4000_0000);
        expect_res("R10 rr victim5", 32'h7000_5000, 1'b1, 1'b0, MISS, 32'd0);
        expect_res("R10 kept6", 32'h7000_6000, 1'b1, 1'b0, HIT, 32'h1000_6000);
        expect_res("R10 new E", 32'h7300_0000, 1'b1, 1'b0, HIT, 32'h5000_0000);
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        rst = 1'b1; lk_valid = 1'b0; lk_va = '0; lk_priv = 1'b0; lk_write = 1'b0;
        dom_ctl = 32'h0000_00E1;   // dom0 client, dom2 reserved, dom3 manager, others none
        rf_valid = 1'b0; rf_vpn = '0; rf_ppn = '0; rf_size = '0; rf_dom = '0; rf_ap = '0;
        rf_cacheable = 1'b0; rf_bufferable = 1'b0;
        mt_valid = 1'b0; mt_op = '0; mt_vpn = '0; mt_lock = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sizes();
        t_quarters();
        t_domains();
        t_invalidate();
        t_same_cycle();
        t_replace();
        finish_up();
    end
endmodule